// File: doc/BRIEF.md
# Multi-Mode Buzzer Tone Generator

The block makes a square-wave tone for a piezo buzzer and drives it on two pins at once: one carries the tone and the other carries its inverse. The tone is built by counting ticks of a 32.768 kHz reference. The reference reaches the block as a one-cycle strobe in the system clock domain.

A 4-bit pitch code selects one of fifteen pitches, from about 964 Hz up to about 5461 Hz. Code 0 gives silence. A 2-bit pattern code selects how the tone is gated:
- continuous sound;
- a one-shot beep of 125 ms that clears its own enable;
- an even on/off blink;
- a double burst that repeats once per second.

All three settings are loaded together by a single write strobe. Every write restarts the pattern from its beginning. When nothing is sounding, both pins sit low, so neither pin holds the buzzer biased while it is idle.

Top module: `tone_buzzer`

## Requirements
- R1: After reset, `bz_p`, `bz_n` and `busy` are all low.
- R2: For a pitch code k from 1 to 15, each half period of the tone lasts 18-k reference ticks, so a full period is 36-2k ticks. The first half after the tone starts is high on `bz_p`.
- R3: Pitch code 0 gives no tone: both pins stay low whatever the enable and pattern settings are.
- R4: While the tone sounds, `bz_n` is the inverse of `bz_p`. When the tone is silent, both pins are low, and the two pins are never high together.
- R5: Pattern code 0 (continuous) sounds for as long as the enable stays set.
- R6: Pattern code 1 (one-shot) sounds for the first 4096 reference ticks after the write. On the tick that completes that span, the enable clears itself, and `busy` goes low.
- R7: Pattern code 2 (blink) sounds for 2048 ticks, is silent for 2048 ticks, and repeats this for as long as the enable stays set.
- R8: Pattern code 3 (double burst) sounds in ticks 0-2047 and 4096-6143 of each 32768-tick window. It is silent for the rest of the window, and the window repeats.
- R9: A new pitch written while the tone sounds takes effect only at the next half-period boundary of the running tone. No half period is ever cut short.
- R10: Every write restarts the pattern from tick 0. Pattern timing and tone timing advance only on cycles where `ref_tick` is high.
- R11: A write with the enable bit low silences both pins from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ref_tick | input | 1 | One-cycle strobe at the 32.768 kHz reference rate |
| cfg_wr | input | 1 | Write strobe that loads the enable, pattern and pitch together |
| cfg_en | input | 1 | Enable value to load |
| cfg_mode | input | 2 | Pattern code: 0 continuous, 1 one-shot, 2 blink, 3 double burst |
| cfg_pitch | input | 4 | Pitch code: 0 silent, 1 to 15 rising pitch |
| bz_p | output | 1 | Buzzer pin, true tone |
| bz_n | output | 1 | Buzzer pin, inverted tone |
| busy | output | 1 | Current state of the enable bit |

## Verification
A fault in the pattern phase counter shows up at the pins within one gating span: a wrongly timed edge of the 2048-tick gate, or a one-shot that ends late. A fault in the half-period counter or in the latched pitch shows up sooner, within one tone period of at most 34 ticks, as an edge that comes too early or too late. The bench keeps a tick-level model of the enable, the phase and the tone level, and compares both pins and `busy` against it on every clock. A wrong state therefore shows as a mismatch in the first cycle where the pins diverge. Stretches where the reference stalls and where the pitch changes in mid-tone make sure that edges slipping in time are caught as well as wrong levels.

// File: rtl/tone_buzzer_pkg.sv
package tone_buzzer_pkg;

  typedef enum logic [1:0] {
    PAT_STEADY  = 2'd0,
    PAT_ONESHOT = 2'd1,
    PAT_BLINK   = 2'd2,
    PAT_DOUBLE  = 2'd3
  } pat_mode_e;

endpackage

// File: rtl/tone_pattern_seq.sv
module tone_pattern_seq
  import tone_buzzer_pkg::*;
#(
  parameter int PITCH_W  = 4,
  parameter int PHASE_W  = 15,
  parameter int GATE_BIT = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ref_tick,
  input  logic               cfg_wr,
  input  logic               cfg_en,
  input  logic [1:0]         cfg_mode,
  input  logic [PITCH_W-1:0] cfg_pitch,
  output logic               en_o,
  output logic [PITCH_W-1:0] pitch_o,
  output logic               sound_o
);

  // one-shot span is two gate spans; double burst ends after three
  localparam logic [PHASE_W-1:0] ONESHOT_LAST = PHASE_W'((2 << GATE_BIT) - 1);
  localparam logic [PHASE_W-1:0] DOUBLE_END   = PHASE_W'(3 << GATE_BIT);
  localparam logic [GATE_BIT:0]  BLINK_EDGE   = {1'b0, {GATE_BIT{1'b1}}};

  logic               en_q,    en_d;
  pat_mode_e          mode_q,  mode_d;
  logic [PITCH_W-1:0] pitch_q, pitch_d;
  logic [PHASE_W-1:0] phase_q, phase_d;
  logic               gate;

  always_comb begin
    en_d    = en_q;
    mode_d  = mode_q;
    pitch_d = pitch_q;
    phase_d = phase_q;
    if (cfg_wr) begin
      en_d    = cfg_en;
      mode_d  = pat_mode_e'(cfg_mode);
      pitch_d = cfg_pitch;
      phase_d = '0;
    end else if (en_q && ref_tick) begin
      phase_d = phase_q + 1'b1;
      if (mode_q == PAT_ONESHOT && phase_q == ONESHOT_LAST) begin
        en_d = 1'b0;
      end
    end
  end

  always_comb begin
    unique case (mode_q)
      PAT_STEADY:  gate = 1'b1;
      PAT_ONESHOT: gate = (phase_q <= ONESHOT_LAST);
      PAT_BLINK:   gate = !phase_q[GATE_BIT];
      PAT_DOUBLE:  gate = !phase_q[GATE_BIT] && (phase_q < DOUBLE_END);
      default:     gate = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      mode_q  <= PAT_STEADY;
      pitch_q <= '0;
      phase_q <= '0;
    end else begin
      en_q    <= en_d;
      mode_q  <= mode_d;
      pitch_q <= pitch_d;
      phase_q <= phase_d;
    end
  end

  assign en_o    = en_q;
  assign pitch_o = pitch_q;
  assign sound_o = en_q && (pitch_q != '0) && gate;

  // R6
  oneshot_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && mode_q == PAT_ONESHOT && ref_tick && !cfg_wr && phase_q == ONESHOT_LAST)
      |=> !en_q);

  // R7
  blink_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && mode_q == PAT_BLINK && ref_tick && !cfg_wr && phase_q[GATE_BIT:0] == BLINK_EDGE)
      |=> !sound_o);

endmodule

// File: rtl/tone_divider.sv
module tone_divider #(
  parameter int PITCH_W   = 4,
  parameter int HALF_BASE = 18
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ref_tick,
  input  logic               sound_i,
  input  logic [PITCH_W-1:0] pitch_i,
  output logic               tone_o
);

  localparam int HC_W = $clog2(HALF_BASE);

  logic [HC_W-1:0]    hc_q,  hc_d;
  logic [PITCH_W-1:0] lat_q, lat_d;
  logic               tone_q, tone_d;
  logic               run_q,  run_d;
  logic [PITCH_W-1:0] eff;
  logic [HC_W-1:0]    half_m1;
  logic               flip;

  // a tone that is just starting takes the current code
  assign eff     = run_q ? lat_q : pitch_i;
  assign half_m1 = HC_W'(HALF_BASE - 1) - HC_W'(eff);
  assign flip    = sound_i && ref_tick && (hc_q == half_m1);

  always_comb begin
    hc_d   = hc_q;
    tone_d = tone_q;
    lat_d  = eff;
    run_d  = sound_i;
    if (!sound_i) begin
      hc_d   = '0;
      tone_d = 1'b1;
      lat_d  = pitch_i;
    end else if (ref_tick) begin
      if (flip) begin
        hc_d   = '0;
        tone_d = !tone_q;
        lat_d  = pitch_i;
      end else begin
        hc_d = hc_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc_q   <= '0;
      tone_q <= 1'b1;
      lat_q  <= '0;
      run_q  <= 1'b0;
    end else begin
      hc_q   <= hc_d;
      tone_q <= tone_d;
      lat_q  <= lat_d;
      run_q  <= run_d;
    end
  end

  assign tone_o = tone_q;

  // R9
  pitch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sound_i && run_q && !flip) |=> (lat_q == $past(lat_q)));

  // R2
  half_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (hc_q <= HC_W'(HALF_BASE - 2)));

endmodule

// File: rtl/tone_out_drive.sv
module tone_out_drive #(
  parameter bit REGISTERED = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sound_i,
  input  logic tone_i,
  output logic bz_p,
  output logic bz_n
);

  logic p_d, n_d;

  assign p_d = sound_i && tone_i;
  assign n_d = sound_i && !tone_i;

  generate
    if (REGISTERED) begin : g_reg
      logic p_q, n_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          p_q <= 1'b0;
          n_q <= 1'b0;
        end else begin
          p_q <= p_d;
          n_q <= n_d;
        end
      end
      assign bz_p = p_q;
      assign bz_n = n_q;
    end else begin : g_comb
      assign bz_p = p_d;
      assign bz_n = n_d;
    end
  endgenerate

  // R4
  pins_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bz_p && bz_n));

endmodule

// File: rtl/tone_buzzer.sv
module tone_buzzer #(
  parameter int PITCH_W   = 4,
  parameter int PHASE_W   = 15,
  parameter int GATE_BIT  = 11,
  parameter int HALF_BASE = 18,
  parameter bit OUT_REG   = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ref_tick,
  input  logic               cfg_wr,
  input  logic               cfg_en,
  input  logic [1:0]         cfg_mode,
  input  logic [PITCH_W-1:0] cfg_pitch,
  output logic               bz_p,
  output logic               bz_n,
  output logic               busy
);

  logic [1:0]         rst_sync;
  logic               rst_core_n;
  logic               sound;
  logic               tone;
  logic [PITCH_W-1:0] pitch_cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  tone_pattern_seq #(
    .PITCH_W (PITCH_W),
    .PHASE_W (PHASE_W),
    .GATE_BIT(GATE_BIT)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .ref_tick (ref_tick),
    .cfg_wr   (cfg_wr),
    .cfg_en   (cfg_en),
    .cfg_mode (cfg_mode),
    .cfg_pitch(cfg_pitch),
    .en_o     (busy),
    .pitch_o  (pitch_cur),
    .sound_o  (sound)
  );

  tone_divider #(
    .PITCH_W  (PITCH_W),
    .HALF_BASE(HALF_BASE)
  ) u_div (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .ref_tick(ref_tick),
    .sound_i (sound),
    .pitch_i (pitch_cur),
    .tone_o  (tone)
  );

  tone_out_drive #(
    .REGISTERED(OUT_REG)
  ) u_drv (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .sound_i(sound),
    .tone_i (tone),
    .bz_p   (bz_p),
    .bz_n   (bz_n)
  );

  // R3
  zero_pitch_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (pitch_cur == '0 && !OUT_REG) |-> !(bz_p || bz_n));

  // R11
  disable_write_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (cfg_wr && !cfg_en && !OUT_REG) |=> !(bz_p || bz_n));

endmodule

// File: tb/tone_buzzer_bench.sv
module tone_buzzer_bench;

  logic       clk;
  logic       rst_n;
  logic       ref_tick;
  logic       cfg_wr;
  logic       cfg_en;
  logic [1:0] cfg_mode;
  logic [3:0] cfg_pitch;
  wire        bz_p;
  wire        bz_n;
  wire        busy;

  int    checks   = 0;
  int    failures = 0;
  string scen     = "R1 reset";
  int    gap      = 1;
  int    cyc      = 0;
  bit    done     = 0;

  // reference model state, in reference ticks
  bit m_en, m_tone, m_run;
  int m_mode, m_pitch, m_phase, m_hc, m_lat;

  tone_buzzer u_tone_buzzer (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_tick (ref_tick),
    .cfg_wr   (cfg_wr),
    .cfg_en   (cfg_en),
    .cfg_mode (cfg_mode),
    .cfg_pitch(cfg_pitch),
    .bz_p     (bz_p),
    .bz_n     (bz_n),
    .busy     (busy)
  );

  initial clk = 1'b0;
  always #4 clk = !clk;

  function automatic bit model_gate();
    case (m_mode)
      0:       return 1'b1;
      1:       return m_phase < 4096;
      2:       return (m_phase % 4096) < 2048;
      default: return (m_phase < 6144) && ((m_phase % 4096) < 2048);
    endcase
  endfunction

  function automatic bit model_sound();
    return m_en && (m_pitch != 0) && model_gate();
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_tone = 1; m_run = 0;
      m_mode = 0; m_pitch = 0; m_phase = 0; m_hc = 0; m_lat = 0;
    end else begin
      bit s;
      int eff;
      s = model_sound();
      if (!s) begin
        m_hc = 0; m_tone = 1; m_run = 0;
      end else begin
        eff = m_run ? m_lat : m_pitch;
        m_lat = eff;
        if (ref_tick) begin
          if (m_hc == 18 - eff - 1) begin
            m_hc = 0; m_tone = !m_tone; m_lat = m_pitch;
          end else begin
            m_hc = m_hc + 1;
          end
        end
        m_run = 1;
      end
      if (cfg_wr) begin
        m_en = cfg_en; m_mode = cfg_mode; m_pitch = cfg_pitch; m_phase = 0;
      end else if (m_en && ref_tick) begin
        if (m_mode == 1 && m_phase == 4095) m_en = 0;
        m_phase = (m_phase + 1) % 32768;
      end
    end
  end

  task automatic check_bit(input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b cycle=%0d", scen, what, act, exp, cyc);
    end
  endtask

  task automatic check_outputs();
    bit s;
    s = model_sound();
    check_bit("bz_p", bz_p, s && m_tone);
    check_bit("bz_n", bz_n, s && !m_tone);
    check_bit("busy", busy, m_en);
  endtask

  task automatic set_ref();
    ref_tick = (gap == 0) ? 1'b0 : ((cyc % gap) == 0);
    cyc++;
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    check_outputs();
    cfg_wr = 1'b0;
    set_ref();
  endtask

  task automatic do_write(input bit e, input int m, input int p);
    @(negedge clk);
    check_outputs();
    cfg_wr    = 1'b1;
    cfg_en    = e;
    cfg_mode  = 2'(m);
    cfg_pitch = 4'(p);
    set_ref();
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) idle_cycle();
  endtask

  task automatic count_rises(input int n, output int rises);
    logic prev;
    prev  = bz_p;
    rises = 0;
    for (int i = 0; i < n; i++) begin
      idle_cycle();
      if (bz_p && !prev) rises++;
      prev = bz_p;
    end
  endtask

  task automatic check_range(input string what, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d..%0d", scen, what, act, lo, hi);
    end
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int r;
    logic hold_p, hold_n;
    rst_n = 1'b0; ref_tick = 1'b0; cfg_wr = 1'b0;
    cfg_en = 1'b0; cfg_mode = 2'd0; cfg_pitch = 4'd0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check_bit("bz_p", bz_p, 1'b0);
    check_bit("bz_n", bz_n, 1'b0);
    check_bit("busy", busy, 1'b0);
    rst_n = 1'b1;
    run(6);

    // R2 top pitch: period 6 ticks; R4 complementary; R5 continuous
    scen = "R2 R4 R5 pitch15";
    do_write(1, 0, 15);
    count_rises(600, r);
    check_range("rises", r, 99, 101);
    do_write(0, 0, 15);
    run(4);

    scen = "R2 pitch1";
    do_write(1, 0, 1);
    count_rises(680, r);
    check_range("rises", r, 19, 21);

    // R9 pitch change mid-tone, several times at odd offsets
    scen = "R9 pitch change";
    run(7);
    do_write(1, 0, 14);
    run(23);
    do_write(1, 0, 3);
    run(5);
    do_write(1, 0, 9);
    run(100);

    // R11 disabling write silences next cycle
    scen = "R11 disable";
    do_write(0, 0, 9);
    idle_cycle();
    check_bit("bz_p_off", bz_p, 1'b0);
    check_bit("bz_n_off", bz_n, 1'b0);
    run(10);

    // R3 code zero gives no tone in any pattern
    scen = "R3 zero pitch";
    do_write(1, 0, 0);
    run(150);
    check_bit("bz_p_zero", bz_p, 1'b0);
    do_write(1, 2, 0);
    run(150);
    check_bit("bz_n_zero", bz_n, 1'b0);

    // R6 one-shot
    scen = "R6 oneshot";
    do_write(1, 1, 10);
    run(4200);
    check_bit("busy_cleared", busy, 1'b0);
    check_bit("bz_p_after", bz_p, 1'b0);

    // R7 blink
    scen = "R7 blink";
    do_write(1, 2, 12);
    run(9000);

    // R8 double burst over more than one window
    scen = "R8 double";
    do_write(1, 3, 13);
    run(34500);

    // R10 restart and sparse reference ticks
    scen = "R10 restart sparse";
    gap = 3;
    do_write(1, 2, 7);
    run(3000);
    do_write(1, 2, 7);
    run(12000);
    gap = 0;
    idle_cycle();
    hold_p = bz_p;
    hold_n = bz_n;
    run(120);
    check_bit("bz_p_frozen", bz_p, hold_p);
    check_bit("bz_n_frozen", bz_n, hold_n);
    gap = 1;
    run(500);
    do_write(0, 0, 0);
    run(5);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule